// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a register-mapped SPI master that works through a list of up to sixteen transfers without help from the processor. Each list slot has three words kept in internal storage: a word to send, the word that came back, and a command word that picks the length of that transfer. Software reaches all three stores through one address register and one data port. The data port steps its address on every access, so a run of back-to-back accesses covers consecutive slots.

To start a run, software sets the serial clock shape and divisor, writes the first and last slot numbers, and sets the start bit. The engine then shifts each slot out most-significant bit first, from the first slot to the last one, wrapping past slot 15 to slot 0. It stores each received word in the slot it came from. When the last slot completes, the start bit clears and a finished flag rises, which can drive an interrupt. Software can refill one half of the list while the engine runs the other half.

The register bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. `bus_rdata` follows `bus_addr` combinationally. A read of the data port with `bus_sel` high advances the store address at that edge. The serial pins have no handshake: `miso` is sampled on the clock edge where the engine moves `sck`.

Top module: `qspi_queue_master`

Register offsets (byte address on `bus_addr`, bits 1:0 ignored): 0x00 mode, 0x04 start, 0x08 list pointers, 0x0C interrupt, 0x10 store address, 0x14 store data.

## Requirements
- R1: After reset these all read zero: the mode, start, list-pointer and interrupt registers, the store address register, and every received-word slot. `irq`, `sck` and `mosi` are low after reset.
- R2: The store address register is 6 bits wide and selects a window in bits 5:4. Window 0 (0x00-0x0F) is the send words, window 1 (0x10-0x1F) the received words, window 2 (0x20-0x2F) the command words, and window 3 reads as zero. Every data-port access, read or write, adds one to the address. Writes into windows 1 and 3 change nothing.
- R3: Writing 1 to start-register bit 15 starts a run. That bit reads 1 while the run is active and reads 0 again once the slot at the end pointer has been shifted and stored.
- R4: A start write has no effect when mode bit 15 (master) is clear, when the divisor in mode bits 7:0 is zero, or when a run is already active. Writes to the mode and list-pointer registers during a run are ignored.
- R5: Every `sck` half-period lasts exactly the divisor number of clock cycles. When no word is being shifted, `sck` sits at CPOL (mode bit 9).
- R6: Word length comes from command bit 14. When bit 14 is clear the word is 8 bits. When it is set, the length comes from mode bits 13:10, where code 0 means 16 bits, codes 1 to 7 mean 8 bits, and codes 8 to 15 give that many bits.
- R7: Each word is sent most-significant bit first from the low bits of its send slot. The received bits are right-aligned, with upper bits zero, in the received slot with the same index.
- R8: With CPHA (mode bit 8) clear, `mosi` carries the first bit before the first `sck` edge, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. With CPHA set, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R9: A run covers the slots from the start pointer (list-pointer bits 3:0) to the end pointer (bits 11:8) inclusive, stepping up and wrapping from 15 to 0. No other received slot is written.
- R10: The finished flag (interrupt bit 0) rises when a run ends. Writing 1 to bit 0 clears it, but a clear in the same cycle that the run ends loses to the set. `irq` is high exactly when the flag and the enable (interrupt bit 8) are both 1.
- R11: The mode register reads back all 16 bits as written. The list-pointer register reads back only bits 11:8 and 3:0; its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register and the serial engine |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Finished flag gated by its enable |

## Verification
Two functions can land in one cycle: the engine setting the finished flag as it stores the last slot, and a software write that clears that flag. The bench provokes this by writing clear-and-enable to the interrupt register on every cycle of a run, so one of those writes always coincides with the final store. The run passes only if `irq` rises while the writes continue and the flag still reads 1 afterwards. A serial slave model in the bench, tracking shift phase and word boundaries, checks the received slots, the captured `mosi` words, every half-period length and the idle `sck` level on each cycle.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  // register select, taken from bus_addr[4:2]
  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_GO   = 3'd1;
  localparam logic [2:0] REG_WRAP = 3'd2;
  localparam logic [2:0] REG_INT  = 3'd3;
  localparam logic [2:0] REG_ADDR = 3'd4;
  localparam logic [2:0] REG_DATA = 3'd5;

  // store windows, taken from the top two bits of the store address
  localparam logic [1:0] WIN_TX  = 2'd0;
  localparam logic [1:0] WIN_RX  = 2'd1;
  localparam logic [1:0] WIN_CMD = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_SHIFT
  } seq_state_t;
endpackage

// File: rtl/qspi_regfile.sv
module qspi_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end
endmodule

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = !clr && (cnt_q == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int W     = 16,
  localparam int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [W-1:0]     tx_word,
  input  logic [LEN_W-1:0] nbits,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             miso,
  output logic             active,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  logic             active_q, sck_q, mosi_q, done_q;
  logic [W-1:0]     tx_q, rx_q;
  logic [LEN_W:0]   edge_q;
  logic [W-1:0]     aligned;
  logic [LEN_W:0]   last_edge;

  assign aligned   = tx_word << (LEN_W'(W) - nbits);
  assign last_edge = {nbits, 1'b0} - (LEN_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      edge_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        sck_q    <= cpol;
        rx_q     <= '0;
        if (!cpha) begin
          mosi_q <= aligned[W-1];
          tx_q   <= aligned << 1;
        end else begin
          tx_q   <= aligned;
        end
      end else if (active_q && tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + (LEN_W+1)'(1);
        // even edge index = leading edge; sample on the edge matching cpha
        if (edge_q[0] == cpha) begin
          rx_q <= {rx_q[W-2:0], miso};
        end else begin
          mosi_q <= tx_q[W-1];
          tx_q   <= tx_q << 1;
        end
        if (edge_q == last_edge) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign active  = active_q;
  assign sck     = active_q ? sck_q : cpol;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master #(
  parameter int DATA_W = 16,
  parameter int QDEPTH = 16,
  parameter int DIV_W  = 8,
  localparam int PTR_W  = $clog2(QDEPTH),
  localparam int RAM_AW = PTR_W + 2,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  import qspi_pkg::*;

  logic [15:0]       mode_q;
  logic [PTR_W-1:0]  start_ptr_q, end_ptr_q, ptr_q;
  logic              int_en_q, flag_q, run_q;
  logic [RAM_AW-1:0] ram_addr_q;
  seq_state_t        state_q;

  logic [2:0]        reg_sel;
  logic              wr_any, mode_wr, go_req, go_ok, int_clr_wr, data_acc;
  logic [1:0]        win;
  logic [PTR_W-1:0]  win_idx;
  logic              tx_we, cmd_we, rx_we, flag_set;
  logic              sh_go, sh_tick, sh_active, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic [LEN_W-1:0]  word_len;
  logic [3:0]        len_code;
  logic [DIV_W-1:0]  cfg_div;
  logic [1:0][DATA_W-1:0] tx_rd, cmd_rd;
  logic [0:0][DATA_W-1:0] rx_rd;

  assign reg_sel    = bus_addr[4:2];
  assign wr_any     = bus_sel && bus_wr;
  assign mode_wr    = wr_any && (reg_sel == REG_MODE);
  assign go_req     = wr_any && (reg_sel == REG_GO) && bus_wdata[15];
  assign cfg_div    = mode_q[DIV_W-1:0];
  assign len_code   = mode_q[13:10];
  assign go_ok      = go_req && !run_q && mode_q[15] && (cfg_div != '0);
  assign int_clr_wr = wr_any && (reg_sel == REG_INT) && bus_wdata[0];
  assign data_acc   = bus_sel && (reg_sel == REG_DATA);
  assign win        = ram_addr_q[RAM_AW-1 -: 2];
  assign win_idx    = ram_addr_q[PTR_W-1:0];
  assign tx_we      = data_acc && bus_wr && (win == WIN_TX);
  assign cmd_we     = data_acc && bus_wr && (win == WIN_CMD);
  assign sh_go      = (state_q == SQ_LOAD);
  assign rx_we      = (state_q == SQ_SHIFT) && sh_done;
  assign flag_set   = rx_we && (ptr_q == end_ptr_q);

  // ---------------- stores: index 0 = bus port, index 1 = engine port
  qspi_regfile #(.W(DATA_W), .DEPTH(QDEPTH), .NRD(2)) u_tx (
    .clk, .rst_n, .we(tx_we), .waddr(win_idx), .wdata(bus_wdata[DATA_W-1:0]),
    .raddr({ptr_q, win_idx}), .rdata(tx_rd));
  qspi_regfile #(.W(DATA_W), .DEPTH(QDEPTH), .NRD(2)) u_cmd (
    .clk, .rst_n, .we(cmd_we), .waddr(win_idx), .wdata(bus_wdata[DATA_W-1:0]),
    .raddr({ptr_q, win_idx}), .rdata(cmd_rd));
  qspi_regfile #(.W(DATA_W), .DEPTH(QDEPTH), .NRD(1)) u_rx (
    .clk, .rst_n, .we(rx_we), .waddr(ptr_q), .wdata(sh_rx),
    .raddr(win_idx), .rdata(rx_rd));

  // ---------------- word length for the slot being loaded
  always_comb begin
    if (!cmd_rd[1][14])         word_len = LEN_W'(8);
    else if (len_code == 4'd0)  word_len = LEN_W'(DATA_W);
    else if (len_code < 4'd8)   word_len = LEN_W'(8);
    else                        word_len = LEN_W'(len_code);
  end

  qspi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk, .rst_n, .clr(!sh_active), .div(cfg_div), .tick(sh_tick));

  qspi_shift #(.W(DATA_W)) u_shift (
    .clk, .rst_n, .go(sh_go), .tick(sh_tick), .tx_word(tx_rd[1]),
    .nbits(word_len), .cpol(mode_q[9]), .cpha(mode_q[8]), .miso,
    .active(sh_active), .sck, .mosi, .done(sh_done), .rx_word(sh_rx));

  // ---------------- registers and list sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      start_ptr_q <= '0;
      end_ptr_q   <= '0;
      int_en_q    <= 1'b0;
      flag_q      <= 1'b0;
      run_q       <= 1'b0;
      ptr_q       <= '0;
      ram_addr_q  <= '0;
      state_q     <= SQ_IDLE;
    end else begin
      if (mode_wr && !run_q) mode_q <= bus_wdata;
      if (wr_any && reg_sel == REG_WRAP && !run_q) begin
        end_ptr_q   <= bus_wdata[8 +: PTR_W];
        start_ptr_q <= bus_wdata[PTR_W-1:0];
      end
      if (wr_any && reg_sel == REG_INT) int_en_q <= bus_wdata[8];
      if (flag_set)        flag_q <= 1'b1;
      else if (int_clr_wr) flag_q <= 1'b0;
      if (wr_any && reg_sel == REG_ADDR) ram_addr_q <= bus_wdata[RAM_AW-1:0];
      else if (data_acc)                 ram_addr_q <= ram_addr_q + RAM_AW'(1);

      unique case (state_q)
        SQ_IDLE: if (go_ok) begin
          run_q   <= 1'b1;
          ptr_q   <= start_ptr_q;
          state_q <= SQ_LOAD;
        end
        SQ_LOAD: state_q <= SQ_SHIFT;
        SQ_SHIFT: if (sh_done) begin
          if (ptr_q == end_ptr_q) begin
            run_q   <= 1'b0;
            state_q <= SQ_IDLE;
          end else begin
            ptr_q   <= ptr_q + PTR_W'(1);
            state_q <= SQ_LOAD;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // ---------------- read mux
  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel)
      REG_MODE: bus_rdata = mode_q;
      REG_GO:   bus_rdata = {run_q, 15'd0};
      REG_WRAP: bus_rdata = (16'(end_ptr_q) << 8) | 16'(start_ptr_q);
      REG_INT:  bus_rdata = {7'd0, int_en_q, 7'd0, flag_q};
      REG_ADDR: bus_rdata = 16'(ram_addr_q);
      REG_DATA: begin
        unique case (win)
          WIN_TX:  bus_rdata = 16'(tx_rd[0]);
          WIN_RX:  bus_rdata = 16'(rx_rd[0]);
          WIN_CMD: bus_rdata = 16'(cmd_rd[0]);
          default: bus_rdata = '0;
        endcase
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && int_en_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], cmd_rd[1][DATA_W-1:15], cmd_rd[1][13:0]};
endmodule

// File: rtl/qspi_queue_master_chk.sv
module qspi_queue_master_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic flag,
  input logic sck,
  input logic go_req,
  input logic div_zero,
  input logic rx_we,
  input logic int_clr_wr,
  input logic mode_wr
);
  AST_DIV0_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !run && div_zero) |=> !run);                       // R4
  AST_RUN_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(go_req));                                // R3
  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> flag);                                         // R10
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr_wr && !run) |=> !flag);                              // R10
  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !mode_wr) |=> $stable(sck));                         // R5
  AST_STORE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> run);                                               // R7
endmodule

bind qspi_queue_master qspi_queue_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .flag(flag_q), .sck(sck),
  .go_req(go_req), .div_zero(cfg_div == '0), .rx_we(rx_we),
  .int_clr_wr(int_clr_wr), .mode_wr(mode_wr));

// File: tb/qspi_queue_master_tb.sv
module qspi_queue_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'h00, A_GO = 5'h04, A_WRAP = 5'h08,
                         A_INT = 5'h0C, A_ADDR = 5'h10, A_DATA = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 1'b0, irq;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  qspi_queue_master dut_i (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .sck, .mosi, .miso, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not end");
    summary();
  end

  task automatic bwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // ---------------- behavioural serial slave and per-cycle reference
  logic        sl_cpol = 1'b0, sl_cpha = 1'b0, sl_arm = 1'b0, idle_chk = 1'b0;
  int          sl_div = 1, sl_n = 0, sl_idx = 0, sl_rxcnt = 0, sl_txpos = 0;
  int          sl_bits [16];
  logic [15:0] sl_word [16];
  logic [15:0] sl_cap  [16];
  logic [15:0] sl_acc = '0;
  logic        prev_sck = 1'b0;
  int          cyc = 0, last_edge = 0;

  function automatic void sl_prep();
    sl_acc = '0; sl_rxcnt = 0;
    if (sl_idx < sl_n) begin
      if (!sl_cpha) begin
        miso = sl_word[sl_idx][sl_bits[sl_idx]-1];
        sl_txpos = sl_bits[sl_idx] - 2;
      end else begin
        sl_txpos = sl_bits[sl_idx] - 1;
      end
    end else begin
      miso = 1'b0;
    end
  endfunction

  task automatic sl_start(input logic pol, input logic pha, input int div, input int n);
    sl_cpol = pol; sl_cpha = pha; sl_div = div; sl_n = n; sl_idx = 0;
    prev_sck = sck;
    sl_prep();
    sl_arm = 1'b1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sl_arm && sck !== prev_sck) begin
      if (sck == sl_cpol) chk("R5 half period", cyc - last_edge, sl_div);
      last_edge = cyc;
      if (sl_idx < sl_n) begin
        if (sck != sl_cpol) begin
          if (!sl_cpha) begin sl_acc = {sl_acc[14:0], mosi}; sl_rxcnt++; end
          else begin miso = sl_word[sl_idx][sl_txpos]; sl_txpos--; end
        end else begin
          if (sl_cpha) begin sl_acc = {sl_acc[14:0], mosi}; sl_rxcnt++; end
          if (sl_rxcnt == sl_bits[sl_idx]) begin
            sl_cap[sl_idx] = sl_acc; sl_idx++; sl_prep();
          end else if (!sl_cpha) begin
            miso = sl_word[sl_idx][sl_txpos]; sl_txpos--;
          end
        end
      end
    end
    prev_sck = sck;
    if (idle_chk) chk("R5 idle sck level", int'(sck), int'(sl_cpol));
  end

  task automatic wait_idle(input string req);
    logic [15:0] r;
    int guard = 0;
    do begin brd(A_GO, r); guard++; end while (r[15] && guard < 20000);
    chk(req, int'(r[15]), 0);
  endtask

  // ---------------- stimulus
  initial begin
    logic [15:0] r;
    logic [15:0] txw [16];
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    brd(A_MODE, r); chk("R1 mode", r, 0);
    brd(A_GO,   r); chk("R1 start", r, 0);
    brd(A_WRAP, r); chk("R1 pointers", r, 0);
    brd(A_INT,  r); chk("R1 interrupt", r, 0);
    brd(A_ADDR, r); chk("R1 store address", r, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sck", int'(sck), 0);
    chk("R1 mosi", int'(mosi), 0);

    // R2 store window access
    bwr(A_ADDR, 16'h0020);
    bwr(A_DATA, 16'hAAAA); bwr(A_DATA, 16'h5555); bwr(A_DATA, 16'h1234);
    brd(A_ADDR, r); chk("R2 auto increment on write", r, 16'h23);
    bwr(A_ADDR, 16'h0021);
    brd(A_DATA, r); chk("R2 command readback", r, 16'h5555);
    brd(A_DATA, r); chk("R2 auto increment on read", r, 16'h1234);
    bwr(A_ADDR, 16'h0010); bwr(A_DATA, 16'hBEEF);
    bwr(A_ADDR, 16'h0010);
    brd(A_DATA, r); chk("R2 received window not writable", r, 0);
    bwr(A_ADDR, 16'h0030); bwr(A_DATA, 16'h7777);
    bwr(A_ADDR, 16'h0030);
    brd(A_DATA, r); chk("R2 window 3 reads zero", r, 0);

    // R11 register readback
    bwr(A_WRAP, 16'hFFFF); brd(A_WRAP, r); chk("R11 pointer mask", r, 16'h0F0F);
    bwr(A_MODE, 16'h4F55); brd(A_MODE, r); chk("R11 mode readback", r, 16'h4F55);

    // R4 start refused: master clear, then divisor zero
    bwr(A_MODE, 16'h0005); bwr(A_GO, 16'h8000);
    brd(A_GO, r); chk("R4 master clear", r, 0);
    bwr(A_MODE, 16'h8000); bwr(A_GO, 16'h8000);
    sl_cpol = 1'b0; idle_chk = 1'b1;
    repeat (20) @(negedge clk);
    brd(A_GO, r);  chk("R4 divisor zero", r, 0);
    brd(A_INT, r); chk("R4 no finish flag", r, 0);
    idle_chk = 1'b0;

    // Run A: CPOL0 CPHA0, code 12, divisor 3, slots 2..5
    bwr(A_MODE, 16'hB003);
    bwr(A_WRAP, 16'h0502);
    bwr(A_INT,  16'h0100);
    txw[2] = 16'h12A5; txw[3] = 16'h0C3F; txw[4] = 16'hF5A6; txw[5] = 16'h0081;
    bwr(A_ADDR, 16'h0002);
    for (int i = 2; i <= 5; i++) bwr(A_DATA, txw[i]);
    bwr(A_ADDR, 16'h0022);
    bwr(A_DATA, 16'h0000); bwr(A_DATA, 16'h4000);
    bwr(A_DATA, 16'h4000); bwr(A_DATA, 16'h8000);
    sl_bits[0] = 8;  sl_word[0] = 16'h003C;
    sl_bits[1] = 12; sl_word[1] = 16'h0ABC;
    sl_bits[2] = 12; sl_word[2] = 16'h0123;
    sl_bits[3] = 8;  sl_word[3] = 16'h007E;
    sl_start(1'b0, 1'b0, 3, 4);
    bwr(A_GO, 16'h8000);
    brd(A_GO, r); chk("R3 busy while running", int'(r[15]), 1);
    bwr(A_MODE, 16'h8001);
    wait_idle("R3 start bit self-clears");
    sl_arm = 1'b0;
    brd(A_MODE, r); chk("R4 mode write ignored in run", r, 16'hB003);
    chk("R9 all slots shifted", sl_idx, 4);
    chk("R7 mosi slot 2 (8 bit)",  sl_cap[0], 16'h00A5);
    chk("R6 mosi slot 3 (12 bit)", sl_cap[1], 16'h0C3F);
    chk("R7 mosi slot 4 (12 bit)", sl_cap[2], 16'h05A6);
    chk("R6 mosi slot 5 (8 bit)",  sl_cap[3], 16'h0081);
    bwr(A_ADDR, 16'h0010);
    brd(A_DATA, r); chk("R9 slot 0 untouched", r, 0);
    brd(A_DATA, r); chk("R9 slot 1 untouched", r, 0);
    brd(A_DATA, r); chk("R7 received slot 2", r, 16'h003C);
    brd(A_DATA, r); chk("R7 received slot 3", r, 16'h0ABC);
    brd(A_DATA, r); chk("R7 received slot 4", r, 16'h0123);
    brd(A_DATA, r); chk("R7 received slot 5", r, 16'h007E);
    brd(A_DATA, r); chk("R9 slot 6 untouched", r, 0);
    brd(A_INT, r);  chk("R10 flag and enable", r, 16'h0101);
    chk("R10 irq high", int'(irq), 1);
    idle_chk = 1'b1; repeat (10) @(negedge clk); idle_chk = 1'b0;

    // Run B: CPOL1 CPHA1, code 0 (16 bit), divisor 2, slots 14..1 wrapping
    bwr(A_INT, 16'h0001);
    brd(A_INT, r); chk("R10 write one clears flag", r, 0);
    chk("R10 irq low after clear", int'(irq), 0);
    bwr(A_MODE, 16'h8302);
    bwr(A_WRAP, 16'h010E);
    bwr(A_ADDR, 16'h000E); bwr(A_DATA, 16'h8001); bwr(A_DATA, 16'h7FFE);
    bwr(A_ADDR, 16'h0000); bwr(A_DATA, 16'hC3A5); bwr(A_DATA, 16'h0F0F);
    bwr(A_ADDR, 16'h002E); bwr(A_DATA, 16'h4000); bwr(A_DATA, 16'h4000);
    bwr(A_ADDR, 16'h0020); bwr(A_DATA, 16'h4000); bwr(A_DATA, 16'h4000);
    sl_bits[0] = 16; sl_word[0] = 16'hDEAD;
    sl_bits[1] = 16; sl_word[1] = 16'hBEEF;
    sl_bits[2] = 16; sl_word[2] = 16'h5A5A;
    sl_bits[3] = 16; sl_word[3] = 16'h0001;
    sl_start(1'b1, 1'b1, 2, 4);
    bwr(A_GO, 16'h8000);
    wait_idle("R3 start bit clears after wrap run");
    sl_arm = 1'b0;
    chk("R9 wrap run slot count", sl_idx, 4);
    chk("R8 mosi slot 14", sl_cap[0], 16'h8001);
    chk("R8 mosi slot 15", sl_cap[1], 16'h7FFE);
    chk("R8 mosi slot 0",  sl_cap[2], 16'hC3A5);
    chk("R8 mosi slot 1",  sl_cap[3], 16'h0F0F);
    bwr(A_ADDR, 16'h001E);
    brd(A_DATA, r); chk("R8 received slot 14", r, 16'hDEAD);
    brd(A_DATA, r); chk("R8 received slot 15", r, 16'hBEEF);
    bwr(A_ADDR, 16'h0010);
    brd(A_DATA, r); chk("R9 received slot 0 after wrap", r, 16'h5A5A);
    brd(A_DATA, r); chk("R6 received slot 1 (16 bit)", r, 16'h0001);
    brd(A_DATA, r); chk("R9 slot 2 keeps earlier word", r, 16'h003C);
    brd(A_INT, r);  chk("R10 flag without enable", r, 16'h0001);
    chk("R10 irq gated off", int'(irq), 0);
    idle_chk = 1'b1; repeat (10) @(negedge clk); idle_chk = 1'b0;

    // Run C: CPOL0 CPHA1, code 3 -> 8 bit, single slot 7, clear hammered each cycle
    bwr(A_INT, 16'h0001);
    bwr(A_MODE, 16'h8D04);
    bwr(A_WRAP, 16'h0707);
    bwr(A_ADDR, 16'h0007); bwr(A_DATA, 16'h01C3);
    bwr(A_ADDR, 16'h0027); bwr(A_DATA, 16'h4000);
    sl_bits[0] = 8; sl_word[0] = 16'h0096;
    sl_start(1'b0, 1'b1, 4, 1);
    bwr(A_GO, 16'h8000);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_INT; bus_wdata = 16'h0101;
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R10 set wins over same-cycle clear", int'(seen), 1);
    sl_arm = 1'b0;
    brd(A_INT, r); chk("R10 flag kept after coincident clear", r, 16'h0101);
    brd(A_GO, r);  chk("R3 start clear after single slot", r, 0);
    chk("R6 code below 8 gives 8 bit mosi", sl_cap[0], 16'h00C3);
    bwr(A_ADDR, 16'h0017);
    brd(A_DATA, r); chk("R8 received slot 7", r, 16'h0096);

    summary();
  end
endmodule